// File: doc/BRIEF.md
# Multi-channel DAC loading sequencer

This block is the digital front end of a six-channel column driver. Ten-bit words arrive on one shared parallel bus, paced by a word clock. The block steers each word into a per-channel first-stage register, either in a running sequence or to a channel picked by address. A transfer pulse then copies every first-stage register into its second-stage register on the same cycle, so all DAC codes change together. A polarity flag is registered alongside the codes.

The word clock is oversampled by the system clock. A capture event is a rising or a falling transition of the word clock, chosen by `edge_fall`. Two such blocks on one bus can therefore take alternate words. In sequence mode (`addr_mode` low), `start_cs` acts as a start pulse. In address mode it acts as a chip select. The direction input lets a frame be loaded into the channels in mirrored order. Several blocks can share one bus in a chain, because each one stops after six words.

Top module: `dac_load_seq`

## Requirements
- R1: After reset, every second-stage code reads 0, `pol_out` reads 0 and the sequencer is idle: capture events in sequence mode write nothing until a start pulse.
- R2: With `edge_fall`=0 a word is captured in the system-clock cycle where `word_clk` is first seen high after being low. With `edge_fall`=1 it is captured where `word_clk` is first seen low after being high. The value on `word_data` in that cycle is the one stored.
- R3: A start pulse with `dir_down`=0 loads the next six captured words into channels 0,1,2,3,4,5 in that order.
- R4: A start pulse with `dir_down`=1 loads the next six captured words into channels 5,4,3,2,1,0 in that order.
- R5: The load direction is taken when the start pulse arrives. Changing `dir_down` in the middle of a sequence does not alter where the remaining words go.
- R6: After the sixth word of a sequence, further capture events are ignored until the next start pulse.
- R7: With `addr_mode`=1 and `start_cs`=1, a capture event writes `word_data` into the channel numbered by `ch_addr`. With `start_cs`=0, nothing is written.
- R8: In address mode, `ch_addr` values 6 and 7 write no channel.
- R9: Writes reach only the first stage. `dac_codes` changes only on the cycle after `xfer` is high, when all channels take their first-stage values at once. A word written in the same cycle as `xfer` lands in the first stage only.
- R10: `pol_out` takes the value of `pol_in` only on a transfer, in step with the codes.
- R11: While `standby` is high, no first-stage, second-stage, polarity or sequence state changes, and captures are lost. The edge history keeps tracking `word_clk`, so leaving standby causes no spurious capture.
- R12: A start pulse that coincides with a capture event wins: that word is not written, and the next captured word goes to the first channel of the new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice the word rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_clk | input | 1 | Word pacing clock, sampled by `clk` |
| word_data | input | CODE_W | Shared parallel data bus |
| start_cs | input | 1 | Start pulse in sequence mode, chip select in address mode |
| addr_mode | input | 1 | 1 selects addressed writes, 0 selects sequence loading |
| dir_down | input | 1 | 0 loads channels upward, 1 loads them downward |
| edge_fall | input | 1 | 0 captures on rising word-clock edges, 1 on falling edges |
| ch_addr | input | ADDR_W | Channel number for addressed writes |
| xfer | input | 1 | Copies all first-stage codes to the outputs |
| standby | input | 1 | Freezes all state while high |
| pol_in | input | 1 | Polarity value taken on a transfer |
| dac_codes | output | NUM_CH*CODE_W | Second-stage codes, channel i at bits [i*CODE_W +: CODE_W] |
| pol_out | output | 1 | Registered polarity flag |

## Verification
The properties assume that every input is synchronous to `clk` and that `word_clk` holds each level for at least one `clk` cycle. Only under those conditions does a capture event mean exactly one word. They also take reset to be asserted from time zero, so that the first sampled history is the all-zero reset state. The stimulus changes every input only on the falling edge of `clk`. It holds `word_clk` at each level for a full cycle and begins with reset low for several cycles.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    // Run state of the sequence pointer
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Capture edge choice
    typedef enum logic {
        CAP_RISE = 1'b0,
        CAP_FALL = 1'b1
    } cap_edge_e;

endpackage

// File: rtl/dseq_edge_det.sv
module dseq_edge_det
    import dseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic word_clk,
    input  logic edge_fall,
    output logic cap
);

    typedef struct packed {
        logic prev;
    } edge_t;

    edge_t edge_d, edge_q;
    cap_edge_e sel;

    always_comb begin
        sel    = cap_edge_e'(edge_fall);
        edge_d = edge_q;
        // history always tracks the pin, even in standby
        edge_d.prev = word_clk;
        if (sel == CAP_FALL) begin
            cap = edge_q.prev & ~word_clk;
        end else begin
            cap = ~edge_q.prev & word_clk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else begin
            edge_q <= edge_d;
        end
    end

endmodule

// File: rtl/dseq_pointer.sv
module dseq_pointer
    import dseq_pkg::*;
#(
    parameter  int NUM_CH = 6,
    parameter  int IDX_W  = 3,
    localparam int CNT_W  = $clog2(NUM_CH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             start,
    input  logic             cap,
    input  logic             dir_in,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             busy
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_CH - 1);

    typedef struct packed {
        seq_state_e       st;
        logic             dir;
        logic [IDX_W-1:0] ptr;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        wr_en = 1'b0;
        if (!hold) begin
            if (start) begin
                // start outranks a coincident capture
                ptr_d.st  = SEQ_RUN;
                ptr_d.dir = dir_in;
                ptr_d.ptr = dir_in ? LAST_IDX : '0;
                ptr_d.cnt = '0;
            end else if (ptr_q.st == SEQ_RUN && cap) begin
                wr_en     = 1'b1;
                ptr_d.cnt = ptr_q.cnt + 1'b1;
                ptr_d.ptr = ptr_q.dir ? (ptr_q.ptr - 1'b1) : (ptr_q.ptr + 1'b1);
                if (ptr_q.cnt == LAST_CNT) begin
                    ptr_d.st = SEQ_IDLE;
                end
            end
        end
        wr_idx = ptr_q.ptr;
        busy   = (ptr_q.st == SEQ_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '{st: SEQ_IDLE, dir: 1'b0, ptr: '0, cnt: '0};
        end else begin
            ptr_q <= ptr_d;
        end
    end

endmodule

// File: rtl/dseq_bank.sv
module dseq_bank #(
    parameter int NUM_CH = 6,
    parameter int CODE_W = 10,
    parameter int IDX_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hold,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [CODE_W-1:0]        wr_data,
    input  logic                     xfer,
    input  logic                     pol_in,
    output logic [NUM_CH*CODE_W-1:0] stage1_flat,
    output logic [NUM_CH*CODE_W-1:0] stage2_flat,
    output logic                     pol_out
);

    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] s1;
        logic [NUM_CH-1:0][CODE_W-1:0] s2;
        logic                          pol;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (!hold) begin
            if (xfer) begin
                // second stage takes the old first stage
                bank_d.s2  = bank_q.s1;
                bank_d.pol = pol_in;
            end
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (wr_en && wr_idx == IDX_W'(ch)) begin
                    bank_d.s1[ch] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
            assign stage1_flat[g*CODE_W +: CODE_W] = bank_q.s1[g];
            assign stage2_flat[g*CODE_W +: CODE_W] = bank_q.s2[g];
        end
    endgenerate

    assign pol_out = bank_q.pol;

endmodule

// File: rtl/dac_load_seq.sv
module dac_load_seq #(
    parameter  int NUM_CH = 6,
    parameter  int CODE_W = 10,
    parameter  int ADDR_W = 3,
    localparam int IDX_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     word_clk,
    input  logic [CODE_W-1:0]        word_data,
    input  logic                     start_cs,
    input  logic                     addr_mode,
    input  logic                     dir_down,
    input  logic                     edge_fall,
    input  logic [ADDR_W-1:0]        ch_addr,
    input  logic                     xfer,
    input  logic                     standby,
    input  logic                     pol_in,
    output logic [NUM_CH*CODE_W-1:0] dac_codes,
    output logic                     pol_out
);

    logic                     cap;
    logic                     seq_start;
    logic                     seq_cap;
    logic                     seq_wr;
    logic                     seq_busy;
    logic [IDX_W-1:0]         seq_idx;
    logic                     addr_hit;
    logic                     addr_wr;
    logic                     wr_en;
    logic [IDX_W-1:0]         wr_idx;
    logic [NUM_CH*CODE_W-1:0] stage1_flat;

    dseq_edge_det u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_clk  (word_clk),
        .edge_fall (edge_fall),
        .cap       (cap)
    );

    always_comb begin
        seq_start = start_cs & ~addr_mode;
        seq_cap   = cap & ~addr_mode;
        addr_hit  = (int'(ch_addr) < NUM_CH);
        addr_wr   = addr_mode & start_cs & cap & addr_hit & ~standby;
        wr_en     = seq_wr | addr_wr;
        wr_idx    = addr_mode ? ch_addr[IDX_W-1:0] : seq_idx;
    end

    dseq_pointer #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (standby),
        .start  (seq_start),
        .cap    (seq_cap),
        .dir_in (dir_down),
        .wr_en  (seq_wr),
        .wr_idx (seq_idx),
        .busy   (seq_busy)
    );

    dseq_bank #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (standby),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (word_data),
        .xfer        (xfer),
        .pol_in      (pol_in),
        .stage1_flat (stage1_flat),
        .stage2_flat (dac_codes),
        .pol_out     (pol_out)
    );

endmodule

// File: rtl/dac_load_seq_chk.sv
module dac_load_seq_chk #(
    parameter int NUM_CH = 6,
    parameter int CODE_W = 10
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     standby,
    input logic                     xfer,
    input logic                     pol_in,
    input logic                     pol_out,
    input logic [NUM_CH*CODE_W-1:0] dac_codes,
    input logic [NUM_CH*CODE_W-1:0] stage1_flat,
    input logic                     seq_wr,
    input logic                     addr_wr,
    input logic                     seq_busy,
    input logic                     seq_start
);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> ($stable(dac_codes) && $stable(pol_out)));

    assert_no_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(dac_codes));

    assert_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !standby) |=> (dac_codes == $past(stage1_flat)));

    assert_pol_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !standby) |=> (pol_out == $past(pol_in)));

    assert_one_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seq_wr, addr_wr}));

    assert_stay_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy && !seq_start) |=> !seq_busy);

endmodule

bind dac_load_seq dac_load_seq_chk #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby     (standby),
    .xfer        (xfer),
    .pol_in      (pol_in),
    .pol_out     (pol_out),
    .dac_codes   (dac_codes),
    .stage1_flat (stage1_flat),
    .seq_wr      (seq_wr),
    .addr_wr     (addr_wr),
    .seq_busy    (seq_busy),
    .seq_start   (seq_start)
);

// File: tb/dac_load_seq_tb_top.sv
`timescale 1ns/1ps
module dac_load_seq_tb_top;

    localparam int NCH = 6;
    localparam int CW  = 10;
    localparam int AW  = 3;
    localparam int NVEC = 10;

    // address-mode vectors: {address, data}
    localparam logic [AW+CW-1:0] VEC [NVEC] = '{
        {3'd0, 10'd17},  {3'd5, 10'd1023}, {3'd2, 10'd512}, {3'd6, 10'd44},
        {3'd3, 10'd0},   {3'd7, 10'd99},   {3'd1, 10'd300}, {3'd4, 10'd777},
        {3'd0, 10'd1},   {3'd5, 10'd256}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            word_clk = 1'b0;
    logic [CW-1:0]   word_data = '0;
    logic            start_cs = 1'b0;
    logic            addr_mode = 1'b0;
    logic            dir_down = 1'b0;
    logic            edge_fall = 1'b0;
    logic [AW-1:0]   ch_addr = '0;
    logic            xfer = 1'b0;
    logic            standby = 1'b0;
    logic            pol_in = 1'b0;
    logic [NCH*CW-1:0] dac_codes;
    logic            pol_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [CW-1:0] m1 [NCH];
    logic [CW-1:0] m2 [NCH];
    logic          mpol;

    always #4 clk = ~clk;

    dac_load_seq #(.NUM_CH(NCH), .CODE_W(CW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .word_clk(word_clk), .word_data(word_data),
        .start_cs(start_cs), .addr_mode(addr_mode), .dir_down(dir_down),
        .edge_fall(edge_fall), .ch_addr(ch_addr), .xfer(xfer),
        .standby(standby), .pol_in(pol_in), .dac_codes(dac_codes),
        .pol_out(pol_out)
    );

    function automatic logic [CW-1:0] ch_out(input int c);
        return dac_codes[c*CW +: CW];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < NCH; c++) begin
            chk(req, $sformatf("ch%0d", c), 32'(ch_out(c)), 32'(m2[c]));
        end
        chk(req, "pol", 32'(pol_out), 32'(mpol));
    endtask

    // word held one cycle high, one cycle low
    task automatic send_word(input logic [CW-1:0] v);
        @(negedge clk) word_clk = 1'b1; word_data = v;
        @(negedge clk) word_clk = 1'b0;
    endtask

    task automatic do_start(input logic dir);
        @(negedge clk) addr_mode = 1'b0; dir_down = dir; start_cs = 1'b1;
        @(negedge clk) start_cs = 1'b0;
    endtask

    task automatic addr_write(input logic [AW-1:0] a, input logic [CW-1:0] v);
        @(negedge clk) addr_mode = 1'b1; start_cs = 1'b1; ch_addr = a;
                       word_clk = 1'b1; word_data = v;
        @(negedge clk) word_clk = 1'b0;
        @(negedge clk) start_cs = 1'b0; addr_mode = 1'b0;
    endtask

    task automatic do_xfer(input string req);
        @(negedge clk) xfer = 1'b1;
        if (!standby) begin
            for (int c = 0; c < NCH; c++) m2[c] = m1[c];
            mpol = pol_in;
        end
        @(negedge clk) xfer = 1'b0;
        check_all(req);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin m1[c] = '0; m2[c] = '0; end
        mpol = 1'b0;

        // R1: reset state
        repeat (4) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        send_word(10'd5);          // no start yet: ignored (R1)
        do_xfer("R1");

        // R3: upward sequence, R9: invisible before transfer
        do_start(1'b0);
        for (int i = 0; i < NCH; i++) begin send_word(CW'(100 + i)); m1[i] = CW'(100 + i); end
        check_all("R9");
        do_xfer("R3");

        // R6: seventh word ignored
        send_word(10'd999);
        do_xfer("R6");

        // R4 + R10: downward sequence with polarity set
        pol_in = 1'b1;
        do_start(1'b1);
        for (int i = 0; i < NCH; i++) begin send_word(CW'(200 + i)); m1[NCH-1-i] = CW'(200 + i); end
        do_xfer("R4");
        pol_in = 1'b0;
        check_all("R10");
        do_xfer("R10");

        // R5: direction flipped mid-sequence
        do_start(1'b0);
        for (int i = 0; i < NCH; i++) begin
            if (i == 2) dir_down = 1'b1;
            send_word(CW'(300 + i));
            m1[i] = CW'(300 + i);
        end
        dir_down = 1'b0;
        do_xfer("R5");

        // R12: start coincides with a capture
        @(negedge clk) addr_mode = 1'b0; dir_down = 1'b0; start_cs = 1'b1;
                       word_clk = 1'b1; word_data = 10'd777;
        @(negedge clk) start_cs = 1'b0; word_clk = 1'b0;
        for (int i = 0; i < NCH; i++) begin send_word(CW'(400 + i)); m1[i] = CW'(400 + i); end
        do_xfer("R12");

        // R2: falling-edge capture takes the low-phase data
        edge_fall = 1'b1;
        do_start(1'b0);
        for (int i = 0; i < NCH; i++) begin
            @(negedge clk) word_clk = 1'b1; word_data = CW'(500 + i);
            @(negedge clk) word_clk = 1'b0; word_data = CW'(600 + i);
            m1[i] = CW'(600 + i);
        end
        do_xfer("R2");
        edge_fall = 1'b0;
        // R2: rising-edge capture takes the high-phase data
        do_start(1'b0);
        for (int i = 0; i < NCH; i++) begin
            @(negedge clk) word_clk = 1'b1; word_data = CW'(520 + i);
            @(negedge clk) word_clk = 1'b0; word_data = CW'(620 + i);
            m1[i] = CW'(520 + i);
        end
        do_xfer("R2");

        // R7 / R8: table of addressed writes
        for (int v = 0; v < NVEC; v++) begin
            addr_write(VEC[v][AW+CW-1:CW], VEC[v][CW-1:0]);
            if (int'(VEC[v][AW+CW-1:CW]) < NCH) m1[VEC[v][AW+CW-1:CW]] = VEC[v][CW-1:0];
            do_xfer((int'(VEC[v][AW+CW-1:CW]) < NCH) ? "R7" : "R8");
        end
        // R7: chip select low writes nothing
        @(negedge clk) addr_mode = 1'b1; start_cs = 1'b0; ch_addr = 3'd2;
        send_word(10'd11);
        @(negedge clk) addr_mode = 1'b0;
        do_xfer("R7");

        // R9: write in the same cycle as a transfer
        pol_in = 1'b1;
        @(negedge clk) addr_mode = 1'b1; start_cs = 1'b1; ch_addr = 3'd1;
                       word_clk = 1'b1; word_data = 10'd888; xfer = 1'b1;
        for (int c = 0; c < NCH; c++) m2[c] = m1[c];
        mpol = 1'b1;
        m1[1] = 10'd888;
        @(negedge clk) word_clk = 1'b0; start_cs = 1'b0; xfer = 1'b0; addr_mode = 1'b0;
        check_all("R9");
        do_xfer("R9");

        // R11: standby freezes outputs, first stage and pointer
        do_start(1'b0);
        send_word(10'd40); m1[0] = 10'd40;
        send_word(10'd41); m1[1] = 10'd41;
        pol_in = 1'b0;
        @(negedge clk) standby = 1'b1;
        send_word(10'd90);
        addr_write(3'd4, 10'd91);
        do_xfer("R11");
        do_start(1'b1);
        @(negedge clk) standby = 1'b0;
        for (int i = 2; i < NCH; i++) begin send_word(CW'(50 + i)); m1[i] = CW'(50 + i); end
        do_xfer("R11");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule